// File: doc/BRIEF.md
# Modulated Optical Presence Detector

This block decides whether an object sits in front of each of several reflective optical sensors. The emitters are driven by a square-wave reference made from the system clock, so any light that comes back from an object carries the same modulation. The block reads each sensor's comparator output as an asynchronous digital level and compares it with the reference it sent out. It reports presence only when the returned signal has followed the reference for several whole periods.

Steady ambient light gives a constant level. Lamp flicker and electrical noise give a pattern unrelated to the reference. Neither matches the modulation for long, so neither is reported as an object. A single disagreement between the sensor and the reference withdraws presence at once.

Each sensor level is resynchronised and filtered before it is compared. The reference passes through an identical conditioning path, so both reach the comparison with the same delay. The channels are independent of one another.

Top module: `optical_presence_detector`

## Requirements
- R1: `emitter_ref` is the clock divided by 2^DIV_LOG2 (eight by default) with a 50% duty cycle: four clocks high, then four clocks low. It changes only on the falling clock edge.
- R2: Each `sense_in` bit passes through a SYNC_STAGES-flop synchronizer and the pulse filter. The reference passes through an identical path, so a sensor that echoes `emitter_ref` with no extra delay compares as equal on every cycle.
- R3: When a channel's sampled sensor level differs from the sampled reference level, that channel's match count is cleared. Its `present` bit is low from the next rising edge.
- R4: A channel's `present` bit rises only after MATCH_PERIODS reference periods of unbroken match (32 clocks by default). While the match continues, the bit then stays high and the count stops advancing.
- R5: A sensor held constant high, held constant low, driven with the inverse of the reference, or toggled on every clock never raises `present`.
- R6: Each channel has its own comparison and count. Bit i of `present` depends only on bit i of `sense_in`.
- R7: While `rst` is high on a rising edge, all match counts and every `present` bit are cleared, and the divider restarts. `present` reads 0 and `emitter_ref` reads 0 on the following cycle.
- R8: A sensor level that persists for fewer than FILT_LEN synchronized samples (one clock by default) is ignored. A one-clock inversion inside a matched run leaves `present` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the divider uses its falling edge, everything else its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | NUM_CH | Asynchronous comparator level from each sensor, high when light is received |
| emitter_ref | output | 1 | Modulation reference driving the emitters |
| present | output | NUM_CH | Object-present flag, one bit per channel |

## Verification
On every cycle, the assertions check the following:
- the reference's run lengths;
- that a sampled mismatch drops presence at the next edge;
- that presence never rises before a full matched window, and holds while the match continues;
- that the filter output changes only after a run of agreeing samples;
- the state right after reset.

Only the bench scenarios can show that real signals are told apart. Echoed modulation raises presence. Steady light, darkness, inverted modulation and clock-rate noise never do. A single-clock glitch is absorbed, and each channel reacts only to its own input.

// File: rtl/optdet_pkg.sv
package optdet_pkg;

   // Number of clock cycles of unbroken match needed before presence is declared
   function automatic int unsigned hold_cycles(input int unsigned periods,
                                               input int unsigned div_log2);
      return periods << div_log2;
   endfunction

   // Width of a counter that must reach (n - 1)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/optdet_ref_div.sv
module optdet_ref_div #(
   parameter int unsigned DIV_LOG2 = 3
) (
   input  logic clk,
   input  logic rst,
   output logic ref_o
);
   localparam int unsigned HALF = 1 << (DIV_LOG2 - 1);
   localparam int unsigned RUN_W = optdet_pkg::cnt_width(HALF + 2);

   logic [DIV_LOG2-1:0] phase_q;

   // Divider advances on the falling edge, so the rising-edge samplers see a settled level
   always_ff @(negedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + 1'b1;
   end

   assign ref_o = phase_q[DIV_LOG2-1];

   // Checker: run length of the reference as seen by rising-edge logic
   logic             prev_ref_q;
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_ref_q <= 1'b0;
         run_q      <= '0;
      end else begin
         prev_ref_q <= ref_o;
         if (ref_o != prev_ref_q) run_q <= RUN_W'(1);
         else if (run_q <= RUN_W'(HALF)) run_q <= run_q + 1'b1;
      end
   end

   a_r1_half_period: assert property (@(posedge clk) disable iff (rst)
      run_q <= RUN_W'(HALF))
      else $error("reference run longer than half period");

endmodule

// File: rtl/optdet_cond.sv
module optdet_cond #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic lvl_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_nofilt
         logic lvl_q;
         always_ff @(posedge clk) begin
            if (rst) lvl_q <= 1'b0;
            else     lvl_q <= synced;
         end
         assign lvl_o = lvl_q;
      end else begin : g_filt
         logic [FILT_LEN-1:0] hist_q;
         logic                lvl_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               hist_q <= '0;
               lvl_q  <= 1'b0;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], synced};
               if (&hist_q)       lvl_q <= 1'b1;
               else if (~|hist_q) lvl_q <= 1'b0;
            end
         end
         assign lvl_o = lvl_q;

         // R8: the filtered level only moves to a value held by the whole history window
         a_r8_filter_run: assert property (@(posedge clk) disable iff (rst)
            (lvl_q != $past(lvl_q)) |-> ($past(hist_q) == {FILT_LEN{lvl_q}}))
            else $error("filter output changed without a full agreeing run");
      end
   endgenerate

endmodule

// File: rtl/optdet_chan.sv
module optdet_chan #(
   parameter int unsigned HOLD = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic sense_i,
   input  logic ref_i,
   output logic present_o
);
   localparam int unsigned CNT_W = optdet_pkg::cnt_width(HOLD);
   localparam int unsigned RUN_W = CNT_W + 1;

   logic             smp_sense_q;
   logic             smp_ref_q;
   logic             mismatch;
   logic [CNT_W-1:0] cnt_q;
   logic             present_q;

   // Both levels are captured on the same rising edge
   always_ff @(posedge clk) begin
      if (rst) begin
         smp_sense_q <= 1'b0;
         smp_ref_q   <= 1'b0;
      end else begin
         smp_sense_q <= sense_i;
         smp_ref_q   <= ref_i;
      end
   end

   assign mismatch = smp_sense_q ^ smp_ref_q;

   always_ff @(posedge clk) begin
      if (rst || mismatch) begin
         cnt_q     <= '0;
         present_q <= 1'b0;
      end else if (!present_q) begin
         if (cnt_q == CNT_W'(HOLD - 1)) present_q <= 1'b1;
         else                           cnt_q     <= cnt_q + 1'b1;
      end
   end

   assign present_o = present_q;

   // Checker: consecutive matched cycles, saturating
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (rst || mismatch) run_q <= '0;
      else if (run_q < RUN_W'(HOLD)) run_q <= run_q + 1'b1;
   end

   a_r3_mismatch_drops: assert property (@(posedge clk) disable iff (rst)
      mismatch |=> !present_o)
      else $error("presence survived a mismatch");

   a_r4_no_early_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(present_o) |-> ($past(run_q) >= RUN_W'(HOLD - 1)))
      else $error("presence rose before a full matched window");

   a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
      (present_o && !mismatch) |=> present_o)
      else $error("presence dropped without a mismatch");

endmodule

// File: rtl/optical_presence_detector.sv
module optical_presence_detector #(
   parameter int unsigned NUM_CH        = 3,
   parameter int unsigned DIV_LOG2      = 3,
   parameter int unsigned MATCH_PERIODS = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned FILT_LEN      = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] sense_in,
   output logic              emitter_ref,
   output logic [NUM_CH-1:0] present
);
   localparam int unsigned HOLD = optdet_pkg::hold_cycles(MATCH_PERIODS, DIV_LOG2);

   generate
      if (NUM_CH < 1)        begin : g_bad_ch   $error("NUM_CH must be at least 1");        end
      if (DIV_LOG2 < 1)      begin : g_bad_div  $error("DIV_LOG2 must be at least 1");      end
      if (MATCH_PERIODS < 1) begin : g_bad_mp   $error("MATCH_PERIODS must be at least 1"); end
      if (SYNC_STAGES < 2)   begin : g_bad_sync $error("SYNC_STAGES must be at least 2");   end
   endgenerate

   logic ref_lvl;

   optdet_ref_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk   (clk),
      .rst   (rst),
      .ref_o (emitter_ref)
   );

   // The reference takes the same conditioning path as the sensors, to match latency
   optdet_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_ref_cond (
      .clk   (clk),
      .rst   (rst),
      .raw_i (emitter_ref),
      .lvl_o (ref_lvl)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic sense_lvl;

         optdet_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
            .clk   (clk),
            .rst   (rst),
            .raw_i (sense_in[ch]),
            .lvl_o (sense_lvl)
         );

         optdet_chan #(.HOLD(HOLD)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .sense_i   (sense_lvl),
            .ref_i     (ref_lvl),
            .present_o (present[ch])
         );
      end
   endgenerate

   // R7: one cycle after reset is seen, all flags and the reference are low
   logic rst_seen_q;
   always_ff @(posedge clk) rst_seen_q <= rst;

   a_r7_reset_clears: assert property (@(posedge clk)
      rst_seen_q |-> (present == '0 && emitter_ref == 1'b0))
      else $error("state not cleared by reset");

endmodule

// File: tb/tb_optical_presence_detector.sv
module tb_optical_presence_detector;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;
   localparam int M_LOW = 0, M_HIGH = 1, M_ECHO = 2, M_INV = 3, M_NOISE = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NCH-1:0] sense_in = '0;
   logic           emitter_ref;
   logic [NCH-1:0] present;

   int mode [NCH];
   logic [NCH-1:0] glitch_req = '0;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [NCH-1:0] exp;
      string          tag;
   } exp_item_t;
   exp_item_t sb_q[$];

   optical_presence_detector dut (
      .clk         (clk),
      .rst         (rst),
      .sense_in    (sense_in),
      .emitter_ref (emitter_ref),
      .present     (present)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Sensor model: drives each channel 1 ns after every falling edge
   initial begin
      for (int i = 0; i < NCH; i++) mode[i] = M_LOW;
      forever begin
         @(negedge clk);
         #1;
         for (int i = 0; i < NCH; i++) begin
            logic v;
            case (mode[i])
               M_HIGH:  v = 1'b1;
               M_ECHO:  v = emitter_ref;
               M_INV:   v = ~emitter_ref;
               M_NOISE: v = ~sense_in[i];
               default: v = 1'b0;
            endcase
            if (glitch_req[i]) begin
               v = ~v;
               glitch_req[i] = 1'b0;
            end
            sense_in[i] = v;
         end
      end
   end

   task automatic check_bit(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Driver side of the scoreboard: wait, then queue the expected presence vector
   task automatic expect_after(input int n, input logic [NCH-1:0] exp, input string tag);
      exp_item_t it;
      repeat (n) @(negedge clk);
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   // Monitor side: pops and compares 2 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (present !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %b expected %b", it.tag, present, it.exp);
            end
         end
      end
   end

   task automatic set_modes(input int m0, input int m1, input int m2);
      mode[0] = m0;
      mode[1] = m1;
      mode[2] = m2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic s [16];

      // Reset; release just after a falling edge
      repeat (4) @(negedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      #2;
      check_bit(present[0] | present[1] | present[2], 1'b0, "R7 reset presence");
      check_bit(emitter_ref, 1'b0, "R7 reset reference");

      // R1: reference pattern, four high then four low
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         #2 s[i] = emitter_ref;
      end
      begin
         bit ok = 1;
         for (int i = 0; i < 12; i++) if (s[i] == s[i+4]) ok = 0;
         for (int i = 0; i < 8; i++)  if (s[i] != s[i+8]) ok = 0;
         check_bit(ok, 1'b1, "R1 reference period and duty");
      end

      // R2/R4: echoed modulation, no early rise, then presence
      set_modes(M_ECHO, M_ECHO, M_ECHO);
      expect_after(20, 3'b000, "R4 no presence before window");
      expect_after(40, 3'b111, "R2 R4 echo raises presence");
      expect_after(100, 3'b111, "R4 presence holds while matched");

      // R8: one-clock inversion in the middle of a high phase on channel 1
      @(posedge emitter_ref);
      repeat (2) @(negedge clk);
      glitch_req[1] = 1'b1;
      expect_after(10, 3'b111, "R8 single-clock glitch ignored");

      // R3/R6: steady light on ch0, inverted modulation on ch1, ch2 still echoing
      set_modes(M_HIGH, M_INV, M_ECHO);
      expect_after(15, 3'b100, "R3 R6 mismatch drops only affected channels");
      expect_after(200, 3'b100, "R5 steady high and inverted never present");

      // R5: dark and clock-rate noise
      set_modes(M_LOW, M_NOISE, M_ECHO);
      expect_after(200, 3'b100, "R5 dark and noise never present");

      // R6: recovery of channels 0 and 1
      set_modes(M_ECHO, M_ECHO, M_ECHO);
      expect_after(60, 3'b111, "R6 channels recover independently");

      // R3: ch2 only, steady light
      set_modes(M_ECHO, M_ECHO, M_HIGH);
      expect_after(12, 3'b011, "R3 object removal on ch2");
      set_modes(M_ECHO, M_ECHO, M_ECHO);
      expect_after(60, 3'b111, "R4 ch2 returns after full window");

      // R7: reset in mid-run
      @(negedge clk);
      #1 rst = 1'b1;
      repeat (2) @(negedge clk);
      #2;
      check_bit(present[0] | present[1] | present[2], 1'b0, "R7 mid-run reset clears presence");
      check_bit(emitter_ref, 1'b0, "R7 mid-run reset clears reference");
      @(negedge clk);
      #1 rst = 1'b0;
      expect_after(20, 3'b000, "R7 R4 window restarts after reset");
      expect_after(40, 3'b111, "R7 presence after reset and full window");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule